// File: doc/BRIEF.md
# Partitioned Vector Lane ALU

This block is a vector arithmetic and logic unit with one registered stage. It takes two data operands and a third modifier operand, all of the same width. It produces a single result of that width. On each operation the datapath is split into independent lanes of 8, 16 or 32 bits, and each lane is read as either signed or unsigned. No carry, borrow or comparison crosses a lane boundary.

Compare operations produce lane masks, which are all ones where the test is true and all zeros where it is false. The select operation then takes such a mask as its modifier operand and merges the two data operands bit by bit. A masked replacement therefore takes two operations and no branches. The operands come in on separate ports and the result leaves on its own port, so every operand can be distinct and no source is overwritten.

Top module: `vec_lane_alu`

## Requirements
- R1: While reset is asserted, and after it is released until the first accepted operation, `outValid` is 0 and `outResult` is all zeros.
- R2: An operation presented with `inValid` high at a rising clock edge appears on `outResult` after that edge, and `outValid` is high for exactly that cycle. `outValid` at each edge equals `inValid` at the edge before it.
- R3: When `inValid` is low, `outResult` keeps its previous value.
- R4: `inSize` selects the lane width as follows: 0 gives sixteen 8-bit lanes, 1 gives eight 16-bit lanes, and 2 or 3 give four 32-bit lanes. Lane i occupies bits [i*W +: W].
- R5: Opcode 0 adds each lane pair modulo 2^W. No carry passes into the next lane.
- R6: Opcode 1 gives each lane the smaller of a and b. The comparison is two's complement when `inSigned` is 1 and unsigned when it is 0.
- R7: Opcode 2 gives each lane (a+b+1)>>1, computed in W+1 bits so that it never overflows. The operands are sign-extended when signed and zero-extended when unsigned.
- R8: Opcodes 3, 4 and 5 give the bitwise AND, OR and XOR of a and b. Lane size and signedness have no effect on them.
- R9: Opcode 6 (equal) and opcode 7 (a greater than b, using the signedness of R6) set each lane to all ones when the test holds and to all zeros when it does not.
- R10: Opcode 8 selects bit by bit: each result bit is the b bit where the modifier `opC` bit is 1, and the a bit where it is 0.
- R11: Opcodes 9 to 15 give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation present this cycle |
| inOp | input | 4 | Opcode (see R5 to R11) |
| inSize | input | 2 | Lane width code (see R4) |
| inSigned | input | 1 | 1 selects two's complement lanes |
| opA | input | DATA_W (128) | First data operand |
| opB | input | DATA_W (128) | Second data operand |
| opC | input | DATA_W (128) | Modifier operand (mask for select) |
| outValid | output | 1 | Result register was loaded at the last edge |
| outResult | output | DATA_W (128) | Registered result |

## Verification
The bench builds the block with its default width of 128 bits. At that width all three partitionings are present: 16, 8 and 4 lanes. The bench therefore exercises every lane boundary where a carry, a sign bit or a comparison could leak. Random opcodes, sizes and signedness, including the reserved opcodes and size code 3, are mixed with directed cases. These cover wraparound at all-ones, minimum between the most negative and most positive values, average of two maximum values, and a compare mask fed straight into select.

// File: rtl/vlane_pkg.sv
package vlane_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_MIN = 4'd1,
    OP_AVG = 4'd2,
    OP_AND = 4'd3,
    OP_OR  = 4'd4,
    OP_XOR = 4'd5,
    OP_EQ  = 4'd6,
    OP_GT  = 4'd7,
    OP_SEL = 4'd8
  } vlaneOp_e;

  localparam int NUM_WIDTHS = 3;  // 8, 16, 32

  typedef struct packed {
    logic       loadRes;
    logic       doAdd;
    logic       doMin;
    logic       doAvg;
    logic       doAnd;
    logic       doOr;
    logic       doXor;
    logic       doEq;
    logic       doGt;
    logic       doSel;
    logic       isSigned;
    logic [NUM_WIDTHS-1:0] widthSel;  // one-hot: bit0=8, bit1=16, bit2=32
  } vlaneCtrl_t;

endpackage

// File: rtl/vlane_ctrl.sv
module vlane_ctrl
  import vlane_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic [3:0] inOp,
  input  logic [1:0] inSize,
  input  logic       inSigned,
  output vlaneCtrl_t ctrl,
  output logic       outValid
);

  always_comb begin
    ctrl          = '0;
    ctrl.loadRes  = inValid;
    ctrl.isSigned = inSigned;
    unique case (inSize)
      2'd0:    ctrl.widthSel = 3'b001;
      2'd1:    ctrl.widthSel = 3'b010;
      default: ctrl.widthSel = 3'b100;
    endcase
    case (inOp)
      OP_ADD:  ctrl.doAdd = 1'b1;
      OP_MIN:  ctrl.doMin = 1'b1;
      OP_AVG:  ctrl.doAvg = 1'b1;
      OP_AND:  ctrl.doAnd = 1'b1;
      OP_OR:   ctrl.doOr  = 1'b1;
      OP_XOR:  ctrl.doXor = 1'b1;
      OP_EQ:   ctrl.doEq  = 1'b1;
      OP_GT:   ctrl.doGt  = 1'b1;
      OP_SEL:  ctrl.doSel = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end

endmodule

// File: rtl/vlane_lane.sv
module vlane_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         isSigned,
  input  logic         doAdd,
  input  logic         doMin,
  input  logic         doAvg,
  input  logic         doEq,
  input  logic         doGt,
  output logic [W-1:0] r
);

  logic [W:0] extA, extB, avgSum;
  logic       aLess, aGreater;

  always_comb begin
    extA     = {isSigned & a[W-1], a};
    extB     = {isSigned & b[W-1], b};
    aLess    = $signed(extA) < $signed(extB);
    aGreater = $signed(extB) < $signed(extA);
    avgSum   = extA + extB + {{W{1'b0}}, 1'b1};
    r        = '0;
    if (doAdd)      r = a + b;
    else if (doMin) r = aLess ? a : b;
    else if (doAvg) r = avgSum[W:1];
    else if (doEq)  r = {W{a == b}};
    else if (doGt)  r = {W{aGreater}};
  end

endmodule

// File: rtl/vlane_dp.sv
module vlane_dp
  import vlane_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  vlaneCtrl_t        ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opC,
  output logic [DATA_W-1:0] outResult
);

  logic [DATA_W-1:0] laneRes [NUM_WIDTHS];
  logic [DATA_W-1:0] arithRes, logicRes, nextRes;

  for (genvar gw = 0; gw < NUM_WIDTHS; gw++) begin : g_width
    localparam int W     = 8 << gw;
    localparam int LANES = DATA_W / W;
    for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
      vlane_lane #(.W(W)) i_lane (
        .a       (opA[gl*W +: W]),
        .b       (opB[gl*W +: W]),
        .isSigned(ctrl.isSigned),
        .doAdd   (ctrl.doAdd),
        .doMin   (ctrl.doMin),
        .doAvg   (ctrl.doAvg),
        .doEq    (ctrl.doEq),
        .doGt    (ctrl.doGt),
        .r       (laneRes[gw][gl*W +: W])
      );
    end
  end

  always_comb begin
    arithRes = '0;
    for (int k = 0; k < NUM_WIDTHS; k++)
      if (ctrl.widthSel[k]) arithRes = laneRes[k];
    logicRes = ({DATA_W{ctrl.doAnd}} & (opA & opB))
             | ({DATA_W{ctrl.doOr}}  & (opA | opB))
             | ({DATA_W{ctrl.doXor}} & (opA ^ opB))
             | ({DATA_W{ctrl.doSel}} & ((opA & ~opC) | (opB & opC)));
    nextRes  = arithRes | logicRes;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            outResult <= '0;
    else if (ctrl.loadRes) outResult <= nextRes;
  end

endmodule

// File: rtl/vec_lane_alu.sv
module vec_lane_alu
  import vlane_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [3:0]        inOp,
  input  logic [1:0]        inSize,
  input  logic              inSigned,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opC,
  output logic              outValid,
  output logic [DATA_W-1:0] outResult
);

  vlaneCtrl_t ctrl;

  vlane_ctrl i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .inOp    (inOp),
    .inSize  (inSize),
    .inSigned(inSigned),
    .ctrl    (ctrl),
    .outValid(outValid)
  );

  vlane_dp #(.DATA_W(DATA_W)) i_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .opA      (opA),
    .opB      (opB),
    .opC      (opC),
    .outResult(outResult)
  );

endmodule

// File: rtl/vec_lane_alu_checker.sv
module vec_lane_alu_checker #(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic [3:0]        inOp,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [DATA_W-1:0] opC,
  input logic              outValid,
  input logic [DATA_W-1:0] outResult
);

  always_comb begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!outValid && outResult == '0);
    end
  end

  a_r2_valid_rises: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable(outResult));

  a_r8_xor: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inOp == 4'd5) |=> outResult == ($past(opA) ^ $past(opB)));

  a_r9_equal_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inOp == 4'd6 && opA == opB) |=> (&outResult));

  a_r10_select: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inOp == 4'd8)
      |=> outResult == (($past(opA) & ~$past(opC)) | ($past(opB) & $past(opC))));

  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inOp > 4'd8) |=> outResult == '0);

endmodule

bind vec_lane_alu vec_lane_alu_checker #(.DATA_W(DATA_W)) i_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .inValid  (inValid),
  .inOp     (inOp),
  .opA      (opA),
  .opB      (opB),
  .opC      (opC),
  .outValid (outValid),
  .outResult(outResult)
);

// File: tb/test_vec_lane_alu.sv
module test_vec_lane_alu;

  localparam int DW = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inValid = 1'b0;
  logic [3:0]    inOp = '0;
  logic [1:0]    inSize = '0;
  logic          inSigned = 1'b0;
  logic [DW-1:0] opA = '0, opB = '0, opC = '0;
  logic          outValid;
  logic [DW-1:0] outResult;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  vec_lane_alu i_vec_lane_alu (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inOp(inOp), .inSize(inSize),
    .inSigned(inSigned), .opA(opA), .opB(opB), .opC(opC),
    .outValid(outValid), .outResult(outResult)
  );

  function automatic logic [DW-1:0] model(input logic [3:0] op, input logic [1:0] sz,
                                          input logic sg, input logic [DW-1:0] a,
                                          input logic [DW-1:0] b, input logic [DW-1:0] c);
    logic [DW-1:0] res = '0;
    int w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    longint msk = (longint'(1) << w) - 1;
    case (op)
      4'd3: return a & b;
      4'd4: return a | b;
      4'd5: return a ^ b;
      4'd8: return (a & ~c) | (b & c);
      default: if (op > 4'd8) return '0;
    endcase
    for (int i = 0; i < DW / w; i++) begin
      longint ea = longint'((a >> (i * w)) & DW'(msk));
      longint eb = longint'((b >> (i * w)) & DW'(msk));
      longint sa = (sg && ea[w-1]) ? ea - (longint'(1) << w) : ea;
      longint sb = (sg && eb[w-1]) ? eb - (longint'(1) << w) : eb;
      longint r = 0;
      case (op)
        4'd0: r = ea + eb;
        4'd1: r = (sa < sb) ? ea : eb;
        4'd2: r = (sa + sb + 1) >>> 1;
        4'd6: r = (ea == eb) ? msk : 0;
        4'd7: r = (sa > sb) ? msk : 0;
        default: r = 0;
      endcase
      res |= DW'(r & msk) << (i * w);
    end
    return res;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at negedge, sample result at the following negedge (one register).
  task automatic runOp(input string tag, input logic [3:0] op, input logic [1:0] sz,
                       input logic sg, input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic [DW-1:0] c);
    inValid = 1'b1; inOp = op; inSize = sz; inSigned = sg; opA = a; opB = b; opC = c;
    @(negedge clk);
    inValid = 1'b0;
    check(tag, outResult, model(op, sz, sg, a, b, c));
    check({tag, " R2 valid"}, {127'd0, outValid}, 128'd1);
  endtask

  function automatic logic [DW-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [DW-1:0] held, mask;
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    check("R1 reset result", outResult, '0);
    check("R1 reset valid", {127'd0, outValid}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", outResult, '0);

    // R5 wrap without cross-lane carry
    runOp("R5 add8 wrap", 4'd0, 2'd0, 1'b0, {16{8'hFF}}, {16{8'h01}}, '0);
    runOp("R5 add16 wrap", 4'd0, 2'd1, 1'b0, {8{16'h00FF}}, {8{16'hFF01}}, '0);
    runOp("R5 add32", 4'd0, 2'd2, 1'b0, {4{32'hFFFF_FFFF}}, {4{32'h1}}, '0);
    // R6 signed vs unsigned min
    runOp("R6 min8 signed", 4'd1, 2'd0, 1'b1, {16{8'h80}}, {16{8'h7F}}, '0);
    runOp("R6 min8 unsigned", 4'd1, 2'd0, 1'b0, {16{8'h80}}, {16{8'h7F}}, '0);
    // R7 rounding without overflow
    runOp("R7 avg8 unsigned max", 4'd2, 2'd0, 1'b0, {16{8'hFF}}, {16{8'hFF}}, '0);
    runOp("R7 avg16 signed", 4'd2, 2'd1, 1'b1, {8{16'h7FFF}}, {8{16'h8000}}, '0);
    // R4 size code 3 behaves as 32-bit
    runOp("R4 size3 add", 4'd0, 2'd3, 1'b0, {4{32'h0000_FFFF}}, {4{32'h1}}, '0);
    // R9 compare mask feeding R10 select
    runOp("R9 gt signed", 4'd7, 2'd1, 1'b1, {8{16'h0001}}, {8{16'hFFFF}}, '0);
    mask = outResult;
    runOp("R10 select from mask", 4'd8, 2'd0, 1'b0, {16{8'hAA}}, {16{8'h55}}, mask);
    runOp("R9 eq", 4'd6, 2'd0, 1'b0, {8{16'h1234}}, {8{16'h1299}}, '0);
    runOp("R11 reserved", 4'd12, 2'd0, 1'b0, {16{8'hFF}}, {16{8'hFF}}, '0);
    // R8 logic ops ignore size and sign
    runOp("R8 and", 4'd3, 2'd1, 1'b1, rnd128(), rnd128(), '0);
    runOp("R8 or", 4'd4, 2'd0, 1'b1, rnd128(), rnd128(), '0);

    // R3 hold while idle
    held = outResult;
    opA = rnd128(); opB = rnd128(); inOp = 4'd0;
    repeat (3) @(negedge clk);
    check("R3 hold", outResult, held);
    check("R2 valid low", {127'd0, outValid}, '0);

    // Random mix over R4..R11
    for (int n = 0; n < 600; n++) begin
      logic [3:0] op = 4'($urandom_range(0, 15));
      logic [1:0] sz = 2'($urandom_range(0, 3));
      logic       sg = 1'($urandom);
      logic [DW-1:0] a = rnd128();
      logic [DW-1:0] b = ($urandom_range(0, 3) == 0) ? a : rnd128();
      runOp("R4-random R5 R6 R7 R8 R9 R10 R11", op, sz, sg, a, b, rnd128());
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule